// File: doc/BRIEF.md
# Layer-4 Access Rule Matcher

This block holds one access-control rule and checks it against the transport-layer fields of a header that has already been parsed. The rule has a protocol number and a port test with four modes: off, equal to either bound, inside the bounds, or outside them. It also has an optional masked compare on the TCP flag byte. Software loads the rule one byte at a time through an offset-addressed write port. A separate combinational read port returns any stored byte.

Header fields arrive with a strobe: a 16-bit transport port, the 8-bit protocol number and the flag byte. On the next clock edge the block registers a verdict and raises a result strobe for one cycle. It looks only at transport-layer fields. Other matchers cover link-layer and network-layer rules.

Top module: `l4_rule_match`

## Requirements
- R1: After reset every rule byte reads back as 0x00, `resValid` is low, and the port and flag checks are both off.
- R2: Rule bytes sit at these offsets. 0x00 holds the port mode in bits [1:0]. 0x01 and 0x02 hold bound A (low byte, then high byte). 0x03 and 0x04 hold bound B (low byte, then high byte). 0x05 holds the protocol. 0x06 holds the flag enable in bit 0. 0x07 holds the flag mask and 0x08 the flag value. A read at an offset returns the stored value, with unused bits as zero.
- R3: A write to any offset above 0x08 changes no rule byte, and a read at such an offset returns 0x00.
- R4: `resValid` goes high exactly one cycle after each cycle with `hdrValid` high, and at no other time.
- R5: A result is a hit only if `hdrProto` equals the stored protocol.
- R6: Port mode 00 lets every port pass.
- R7: Port mode 01 passes a port equal to bound A or to bound B.
- R8: Port mode 10 passes a port from min(A,B) to max(A,B), both ends included, whichever bound is larger.
- R9: Port mode 11 passes a port below min(A,B) or above max(A,B).
- R10: With the flag enable at 0 the flag byte has no effect on the result.
- R11: With the flag enable at 1 the check passes only when (hdrFlags AND mask) equals (value AND mask).
- R12: `resHit` is the AND of the protocol, port and flag checks, and it is low whenever `resValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Rule byte write strobe |
| cfgWrOfs | input | 8 | Rule byte write offset |
| cfgWrData | input | 8 | Rule byte write data |
| cfgRdOfs | input | 8 | Rule byte read offset |
| cfgRdData | output | 8 | Rule byte read data (combinational) |
| hdrValid | input | 1 | Header fields valid |
| hdrPort | input | 16 | Transport-layer port |
| hdrProto | input | 8 | IP protocol number |
| hdrFlags | input | 8 | TCP flag byte |
| resValid | output | 1 | Verdict valid, one cycle after hdrValid |
| resHit | output | 1 | Rule matched |

## Verification
The hardest cases to reach are the inclusive edges of the range modes when the two bounds are loaded in swapped order. A bench that always writes the smaller value as the lower bound never reaches them. The stimulus loads bound A above bound B, then sends ports at min-1, min, max and max+1 in both the inside and outside modes. The same sweep runs with the bounds the other way round. Headers are sent back to back and with gaps, so each verdict must pair with its own header in the scoreboard queue.

// File: rtl/l4m_pkg.sv
package l4m_pkg;
  localparam int PORT_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int OFS_W      = 8;
  localparam int PORT_BYTES = PORT_W / BYTE_W;

  typedef enum logic [1:0] {
    PM_OFF     = 2'b00,
    PM_EITHER  = 2'b01,
    PM_INSIDE  = 2'b10,
    PM_OUTSIDE = 2'b11
  } portMode_e;

  localparam logic [OFS_W-1:0] OFS_MODE  = OFS_W'(0);
  localparam logic [OFS_W-1:0] OFS_BNDA  = OFS_W'(1);
  localparam logic [OFS_W-1:0] OFS_BNDB  = OFS_W'(1 + PORT_BYTES);
  localparam logic [OFS_W-1:0] OFS_PROTO = OFS_W'(1 + 2 * PORT_BYTES);
  localparam logic [OFS_W-1:0] OFS_FEN   = OFS_W'(2 + 2 * PORT_BYTES);
  localparam logic [OFS_W-1:0] OFS_FMASK = OFS_W'(3 + 2 * PORT_BYTES);
  localparam logic [OFS_W-1:0] OFS_FVAL  = OFS_W'(4 + 2 * PORT_BYTES);

  typedef struct packed {
    logic                  wrMode;
    logic [PORT_BYTES-1:0] wrBndA;
    logic [PORT_BYTES-1:0] wrBndB;
    logic                  wrProto;
    logic                  wrFen;
    logic                  wrFmask;
    logic                  wrFval;
    logic                  evalStb;
  } ctrlStb_t;
endpackage

// File: rtl/l4m_ctrl.sv
module l4m_ctrl
  import l4m_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [OFS_W-1:0] cfgWrOfs,
  input  logic             hdrValid,
  output ctrlStb_t         stb
);
  always_comb begin
    stb = '0;
    stb.evalStb = hdrValid;
    if (cfgWrEn) begin
      stb.wrMode  = (cfgWrOfs == OFS_MODE);
      stb.wrProto = (cfgWrOfs == OFS_PROTO);
      stb.wrFen   = (cfgWrOfs == OFS_FEN);
      stb.wrFmask = (cfgWrOfs == OFS_FMASK);
      stb.wrFval  = (cfgWrOfs == OFS_FVAL);
      for (int b = 0; b < PORT_BYTES; b++) begin
        stb.wrBndA[b] = (cfgWrOfs == OFS_W'(OFS_BNDA + OFS_W'(b)));
        stb.wrBndB[b] = (cfgWrOfs == OFS_W'(OFS_BNDB + OFS_W'(b)));
      end
    end
  end

  // R2
  one_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrMode, stb.wrBndA, stb.wrBndB, stb.wrProto,
              stb.wrFen, stb.wrFmask, stb.wrFval}));

  // R3
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (cfgWrOfs > OFS_FVAL)) |->
      ({stb.wrMode, stb.wrBndA, stb.wrBndB, stb.wrProto,
        stb.wrFen, stb.wrFmask, stb.wrFval} == '0));
endmodule

// File: rtl/l4m_port_cmp.sv
module l4m_port_cmp
  import l4m_pkg::*;
#(
  parameter int PortW = PORT_W
) (
  input  portMode_e        mode,
  input  logic [PortW-1:0] bndA,
  input  logic [PortW-1:0] bndB,
  input  logic [PortW-1:0] port,
  output logic             portOk
);
  logic [PortW-1:0] loBnd;
  logic [PortW-1:0] hiBnd;
  logic             inRange;
  logic             onBound;

  always_comb begin
    if (bndA < bndB) begin
      loBnd = bndA;
      hiBnd = bndB;
    end else begin
      loBnd = bndB;
      hiBnd = bndA;
    end
    inRange = (port >= loBnd) && (port <= hiBnd);
    onBound = (port == bndA) || (port == bndB);
    unique case (mode)
      PM_OFF:     portOk = 1'b1;
      PM_EITHER:  portOk = onBound;
      PM_INSIDE:  portOk = inRange;
      PM_OUTSIDE: portOk = !inRange;
      default:    portOk = 1'b0;
    endcase
  end
endmodule

// File: rtl/l4m_datapath.sv
module l4m_datapath
  import l4m_pkg::*;
#(
  parameter int PortW  = PORT_W,
  parameter int ProtoW = BYTE_W,
  parameter int FlagW  = BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [BYTE_W-1:0] cfgWrData,
  input  logic [OFS_W-1:0]  cfgRdOfs,
  output logic [BYTE_W-1:0] cfgRdData,
  input  logic [PortW-1:0]  hdrPort,
  input  logic [ProtoW-1:0] hdrProto,
  input  logic [FlagW-1:0]  hdrFlags,
  output logic              resValid,
  output logic              resHit
);
  localparam int NBytes = PortW / BYTE_W;

  portMode_e                     ruleMode;
  logic [NBytes-1:0][BYTE_W-1:0] bndABytes;
  logic [NBytes-1:0][BYTE_W-1:0] bndBBytes;
  logic [ProtoW-1:0]             ruleProto;
  logic                          ruleFen;
  logic [FlagW-1:0]              ruleFmask;
  logic [FlagW-1:0]              ruleFval;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ruleMode  <= PM_OFF;
      ruleProto <= '0;
      ruleFen   <= 1'b0;
      ruleFmask <= '0;
      ruleFval  <= '0;
    end else begin
      if (stb.wrMode)  ruleMode  <= portMode_e'(cfgWrData[1:0]);
      if (stb.wrProto) ruleProto <= cfgWrData[ProtoW-1:0];
      if (stb.wrFen)   ruleFen   <= cfgWrData[0];
      if (stb.wrFmask) ruleFmask <= cfgWrData[FlagW-1:0];
      if (stb.wrFval)  ruleFval  <= cfgWrData[FlagW-1:0];
    end
  end

  for (genvar b = 0; b < NBytes; b++) begin : g_bnd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bndABytes[b] <= '0;
        bndBBytes[b] <= '0;
      end else begin
        if (stb.wrBndA[b]) bndABytes[b] <= cfgWrData;
        if (stb.wrBndB[b]) bndBBytes[b] <= cfgWrData;
      end
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgRdOfs == OFS_MODE)  cfgRdData = BYTE_W'(ruleMode);
    if (cfgRdOfs == OFS_PROTO) cfgRdData = BYTE_W'(ruleProto);
    if (cfgRdOfs == OFS_FEN)   cfgRdData = BYTE_W'(ruleFen);
    if (cfgRdOfs == OFS_FMASK) cfgRdData = BYTE_W'(ruleFmask);
    if (cfgRdOfs == OFS_FVAL)  cfgRdData = BYTE_W'(ruleFval);
    for (int b = 0; b < NBytes; b++) begin
      if (cfgRdOfs == OFS_W'(OFS_BNDA + OFS_W'(b))) cfgRdData = bndABytes[b];
      if (cfgRdOfs == OFS_W'(OFS_BNDB + OFS_W'(b))) cfgRdData = bndBBytes[b];
    end
  end

  logic portOk;
  logic protoOk;
  logic flagOk;

  l4m_port_cmp #(.PortW(PortW)) u_portCmp (
    .mode   (ruleMode),
    .bndA   (bndABytes),
    .bndB   (bndBBytes),
    .port   (hdrPort),
    .portOk (portOk)
  );

  assign protoOk = (hdrProto == ruleProto);
  assign flagOk  = !ruleFen || ((hdrFlags & ruleFmask) == (ruleFval & ruleFmask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resHit   <= 1'b0;
    end else begin
      resValid <= stb.evalStb;
      resHit   <= stb.evalStb && protoOk && portOk && flagOk;
    end
  end

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.evalStb |=> resValid);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.evalStb |=> !resValid);

  // R5
  proto_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evalStb && (hdrProto != ruleProto)) |=> !resHit);

  // R11
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evalStb && ruleFen && (((hdrFlags ^ ruleFval) & ruleFmask) != '0)) |=> !resHit);

  // R12
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    resHit |-> resValid);

  // R3
  rule_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|{stb.wrMode, stb.wrBndA, stb.wrBndB, stb.wrProto, stb.wrFen, stb.wrFmask, stb.wrFval})
      |=> ($stable(ruleMode) && $stable(bndABytes) && $stable(bndBBytes) &&
           $stable(ruleProto) && $stable(ruleFen) && $stable(ruleFmask) && $stable(ruleFval)));
endmodule

// File: rtl/l4_rule_match.sv
module l4_rule_match
  import l4m_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [OFS_W-1:0]  cfgWrOfs,
  input  logic [BYTE_W-1:0] cfgWrData,
  input  logic [OFS_W-1:0]  cfgRdOfs,
  output logic [BYTE_W-1:0] cfgRdData,
  input  logic              hdrValid,
  input  logic [PORT_W-1:0] hdrPort,
  input  logic [BYTE_W-1:0] hdrProto,
  input  logic [BYTE_W-1:0] hdrFlags,
  output logic              resValid,
  output logic              resHit
);
  ctrlStb_t stb;

  l4m_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgWrOfs (cfgWrOfs),
    .hdrValid (hdrValid),
    .stb      (stb)
  );

  l4m_datapath #(
    .PortW  (PORT_W),
    .ProtoW (BYTE_W),
    .FlagW  (BYTE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgWrData (cfgWrData),
    .cfgRdOfs  (cfgRdOfs),
    .cfgRdData (cfgRdData),
    .hdrPort   (hdrPort),
    .hdrProto  (hdrProto),
    .hdrFlags  (hdrFlags),
    .resValid  (resValid),
    .resHit    (resHit)
  );
endmodule

// File: tb/l4_rule_match_test.sv
`timescale 1ns/100ps
module l4_rule_match_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrOfs = '0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdOfs = '0;
  logic [7:0]  cfgRdData;
  logic        hdrValid = 1'b0;
  logic [15:0] hdrPort = '0;
  logic [7:0]  hdrProto = '0;
  logic [7:0]  hdrFlags = '0;
  logic        resValid;
  logic        resHit;

  int total = 0;
  int bad = 0;
  bit    expQ[$];
  string tagQ[$];

  logic [1:0]  mMode = '0;
  logic [15:0] mA = '0;
  logic [15:0] mB = '0;
  logic [7:0]  mProto = '0;
  logic        mFen = 1'b0;
  logic [7:0]  mMask = '0;
  logic [7:0]  mVal = '0;

  always #2.5 clk = ~clk;

  l4_rule_match uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrOfs(cfgWrOfs),
    .cfgWrData(cfgWrData), .cfgRdOfs(cfgRdOfs), .cfgRdData(cfgRdData),
    .hdrValid(hdrValid), .hdrPort(hdrPort), .hdrProto(hdrProto),
    .hdrFlags(hdrFlags), .resValid(resValid), .resHit(resHit)
  );

  function automatic logic [7:0] modelRead(input logic [7:0] ofs);
    case (ofs)
      8'h00: return {6'b0, mMode};
      8'h01: return mA[7:0];
      8'h02: return mA[15:8];
      8'h03: return mB[7:0];
      8'h04: return mB[15:8];
      8'h05: return mProto;
      8'h06: return {7'b0, mFen};
      8'h07: return mMask;
      8'h08: return mVal;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit modelHit(input logic [15:0] p, input logic [7:0] pr, input logic [7:0] fl);
    logic [15:0] lo;
    logic [15:0] hi;
    bit portPass;
    bit flagPass;
    lo = (mA < mB) ? mA : mB;
    hi = (mA < mB) ? mB : mA;
    case (mMode)
      2'b00: portPass = 1;
      2'b01: portPass = (p == mA) || (p == mB);
      2'b10: portPass = (p >= lo) && (p <= hi);
      default: portPass = (p < lo) || (p > hi);
    endcase
    flagPass = !mFen || ((fl & mMask) == (mVal & mMask));
    return (pr == mProto) && portPass && flagPass;
  endfunction

  task automatic wrCfg(input logic [7:0] ofs, input logic [7:0] data);
    @(negedge clk);
    hdrValid = 1'b0;
    cfgWrEn = 1'b1;
    cfgWrOfs = ofs;
    cfgWrData = data;
    case (ofs)
      8'h00: mMode = data[1:0];
      8'h01: mA[7:0] = data;
      8'h02: mA[15:8] = data;
      8'h03: mB[7:0] = data;
      8'h04: mB[15:8] = data;
      8'h05: mProto = data;
      8'h06: mFen = data[0];
      8'h07: mMask = data;
      8'h08: mVal = data;
      default: ;
    endcase
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setBounds(input logic [15:0] a, input logic [15:0] b);
    wrCfg(8'h01, a[7:0]);
    wrCfg(8'h02, a[15:8]);
    wrCfg(8'h03, b[7:0]);
    wrCfg(8'h04, b[15:8]);
  endtask

  task automatic rdCheck(input logic [7:0] ofs, input string tag);
    logic [7:0] exp;
    cfgRdOfs = ofs;
    #1;
    exp = modelRead(ofs);
    total++;
    if (cfgRdData !== exp) begin
      bad++;
      $display("FAIL %s read ofs=%0h actual=%0h expected=%0h", tag, ofs, cfgRdData, exp);
    end
  endtask

  task automatic sendHdr(input logic [15:0] p, input logic [7:0] pr, input logic [7:0] fl,
                         input string tag);
    @(negedge clk);
    hdrValid = 1'b1;
    hdrPort = p;
    hdrProto = pr;
    hdrFlags = fl;
    expQ.push_back(modelHit(p, pr, fl));
    tagQ.push_back(tag);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hdrValid = 1'b0;
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN) begin
        if (resValid !== (expQ.size() > 0)) begin
          total++;
          bad++;
          $display("FAIL R4 resValid actual=%0b expected=%0b", resValid, expQ.size() > 0);
          if (expQ.size() > 0) begin
            void'(expQ.pop_front());
            void'(tagQ.pop_front());
          end
        end else if (resValid) begin
          bit e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          total++;
          if (resHit !== e) begin
            bad++;
            $display("FAIL %s resHit actual=%0b expected=%0b", t, resHit, e);
          end
        end else if (resHit !== 1'b0) begin
          total++;
          bad++;
          $display("FAIL R12 resHit without valid actual=%0b expected=0", resHit);
        end
      end
    end
  end

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if (resValid !== 1'b0) begin
      bad++;
      $display("FAIL R1 resValid actual=%0b expected=0", resValid);
    end
    for (int o = 0; o < 9; o++) rdCheck(8'(o), "R1");
    rstN = 1'b1;
    gap(1);

    // R1/R6/R10: default rule, protocol 0 hits for any port and flags
    sendHdr(16'h1234, 8'h00, 8'hFF, "R1");
    sendHdr(16'h0000, 8'h00, 8'h00, "R6");
    sendHdr(16'hFFFF, 8'h00, 8'h5A, "R10");
    // R5 protocol mismatch
    sendHdr(16'h1234, 8'h06, 8'h00, "R5");
    gap(2);

    // R2 write every field and read back
    wrCfg(8'h00, 8'hFD);
    setBounds(16'h01BB, 16'h0050);
    wrCfg(8'h05, 8'h06);
    wrCfg(8'h06, 8'h01);
    wrCfg(8'h07, 8'h12);
    wrCfg(8'h08, 8'h02);
    for (int o = 0; o < 9; o++) rdCheck(8'(o), "R2");

    // R3 unused offsets are ignored
    wrCfg(8'h09, 8'hFF);
    wrCfg(8'h20, 8'hAA);
    wrCfg(8'hFF, 8'h55);
    for (int o = 0; o < 9; o++) rdCheck(8'(o), "R3");
    rdCheck(8'h09, "R3");
    rdCheck(8'hFF, "R3");

    // R11 masked flags (mode 01 from 0xFD, bounds 0x01BB and 0x0050)
    sendHdr(16'h0050, 8'h06, 8'h02, "R11");
    sendHdr(16'h0050, 8'h06, 8'hED, "R11");
    sendHdr(16'h0050, 8'h06, 8'h12, "R11");
    sendHdr(16'h0050, 8'h06, 8'h10, "R11");
    // R12 port ok, flags fail / flags ok, port fail
    sendHdr(16'h01BB, 8'h06, 8'h00, "R12");
    sendHdr(16'h0051, 8'h06, 8'h02, "R12");
    gap(2);

    // R10 flags ignored when enable is 0
    wrCfg(8'h06, 8'h00);
    sendHdr(16'h01BB, 8'h06, 8'h00, "R10");
    sendHdr(16'h01BB, 8'h06, 8'hFF, "R10");
    gap(1);

    // R7 either bound
    wrCfg(8'h00, 8'h01);
    sendHdr(16'h01BB, 8'h06, 8'h00, "R7");
    sendHdr(16'h0050, 8'h06, 8'h00, "R7");
    sendHdr(16'h0100, 8'h06, 8'h00, "R7");
    gap(1);

    // R8 inside, bound A above bound B, then swapped
    wrCfg(8'h00, 8'h02);
    for (int s = 0; s < 2; s++) begin
      if (s == 1) setBounds(16'h0050, 16'h01BB);
      sendHdr(16'h004F, 8'h06, 8'h00, "R8");
      sendHdr(16'h0050, 8'h06, 8'h00, "R8");
      sendHdr(16'h0100, 8'h06, 8'h00, "R8");
      sendHdr(16'h01BB, 8'h06, 8'h00, "R8");
      sendHdr(16'h01BC, 8'h06, 8'h00, "R8");
      gap(1);
    end

    // R9 outside, both bound orders
    wrCfg(8'h00, 8'h03);
    for (int s = 0; s < 2; s++) begin
      if (s == 1) setBounds(16'h01BB, 16'h0050);
      sendHdr(16'h004F, 8'h06, 8'h00, "R9");
      sendHdr(16'h0050, 8'h06, 8'h00, "R9");
      sendHdr(16'h01BB, 8'h06, 8'h00, "R9");
      sendHdr(16'h01BC, 8'h06, 8'h00, "R9");
      sendHdr(16'h0000, 8'h06, 8'h00, "R9");
      gap(1);
    end

    // R6 mode 00 lets every port through
    wrCfg(8'h00, 8'h00);
    sendHdr(16'h0100, 8'h06, 8'h00, "R6");
    sendHdr(16'hFFFF, 8'h06, 8'h00, "R6");
    // R5 with port passing
    sendHdr(16'hFFFF, 8'h11, 8'h00, "R5");
    gap(4);

    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R4 pending results actual=%0d expected=0", expQ.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule